// File: doc/BRIEF.md
# Split-link column data interleaver

This block sits between the column read path of a finely banked DRAM core and its sixteen data links. It takes one 64-bit column word at a time, each tagged with the number of the bank that produced it. It then serialises the word onto one half of the links. Bank parity picks the half: even banks use links 0 to 7 and odd banks use links 8 to 15. Each access holds its half for eight bit times, which is half of a sixteen-bit-time column window.

Each column window is split into two slots. The first slot belongs to the lower quadrants and the second to the upper quadrants, and the top bank bit chooses the quadrant. Both halves use the same slot timing, so an upper and a lower access can share a link half without colliding. A slot with nothing pending stays at zero.

Each half holds one staged word per slot. A word that finds its slot already staged waits in one shared spare register. It moves forward when that slot frees up.

Top module: `mtil_interleaver`

## Requirements
- R1: While reset is asserted, and in the first cycle after it is released, all sixteen links are 0 and both beat markers are low.
- R2: A free-running phase counter (0 to 15) starts at 0 after reset and advances by one every cycle. Phases 0 to 7 form the lower slot (bank bit 3 = 0) and phases 8 to 15 form the upper slot (bank bit 3 = 1). An access never runs past the end of its slot.
- R3: Bank bit 0 selects the link half. 0 drives `link_o[7:0]` and 1 drives `link_o[15:8]`. The other half is not disturbed.
- R4: At beat t (t = phase mod 8) of an access, link k of the chosen half carries bit 8k+t of the word. Byte k therefore goes out on link k, low bit first.
- R5: A half's beat marker is high for exactly the eight cycles of each slot in which that half sends a word, and low otherwise.
- R6: In a slot with no word for a half, that half's links are all 0.
- R7: A word presented in the cycle at phase p goes out in the first slot of its quadrant whose first beat falls at least two cycles after that cycle. A word presented at phase 7 for the upper slot therefore misses the next cycle's slot and waits a full window.
- R8: Words for the same half and quadrant go out in arrival order, one per window.
- R9: Each half accepts up to three pending words without loss, with at most two for one quadrant. A word for a quadrant that has nothing staged bypasses a spare-held word of the other quadrant.
- R10: The two halves run independently, so an A access and a B access can share the same slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit-time clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| col_valid | input | 1 | A column word is presented this cycle |
| col_bank | input | 4 | Bank number of the presented word |
| col_data | input | 64 | Column read word |
| link_o | output | 16 | Serial link bits; [7:0] is the even-bank half, [15:8] the odd-bank half |
| beat_a_o | output | 1 | Even-bank half is sending a word this beat |
| beat_b_o | output | 1 | Odd-bank half is sending a word this beat |

## Verification
The assertions assume the source never overruns a half. That means no more than two words for one quadrant and three in total are waiting on a half when a new one arrives. A word beyond that would be lost, and the overflow property flags it.

The random stimulus keeps a transaction-level queue for each half and quadrant. It offers a word only when those queues leave room. The directed cases stay inside the same limit while filling a half to three pending words.

// File: rtl/mtil_pkg.sv
package mtil_pkg;
    typedef logic slot_t;
    localparam slot_t SLOT_LOWER = 1'b0;
    localparam slot_t SLOT_UPPER = 1'b1;
    localparam int unsigned NUM_HALVES = 2;
    localparam int unsigned SLOTS_PER_WINDOW = 2;
endpackage

// File: rtl/mtil_phase.sv
module mtil_phase
    import mtil_pkg::*;
#(
    parameter int unsigned BEATS = 8,
    localparam int unsigned BEAT_W = $clog2(BEATS),
    localparam int unsigned PH_W = BEAT_W + 1
) (
    input  logic            clk,
    input  logic            rst_n,
    output logic [PH_W-1:0] ph,
    output logic            slot_end,
    output slot_t           nxt_slot
);
    typedef struct packed {
        logic [PH_W-1:0] ph;
    } st_t;

    st_t s_d, s_q;

    always_comb begin
        s_d    = s_q;
        s_d.ph = s_q.ph + PH_W'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    // Last beat of the current slot; the following slot is the other one.
    assign ph       = s_q.ph;
    assign slot_end = &s_q.ph[BEAT_W-1:0];
    assign nxt_slot = s_q.ph[PH_W-1] ? SLOT_LOWER : SLOT_UPPER;
endmodule

// File: rtl/mtil_half.sv
module mtil_half
    import mtil_pkg::*;
#(
    parameter int unsigned LINKS = 8,
    parameter int unsigned BEATS = 8,
    localparam int unsigned BEAT_W = $clog2(BEATS),
    localparam int unsigned WORD_W = LINKS * BEATS
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [BEAT_W-1:0] beat_idx,
    input  logic              slot_end,
    input  slot_t             nxt_slot,
    input  logic              in_v,
    input  slot_t             in_slot,
    input  logic [WORD_W-1:0] in_word,
    output logic [LINKS-1:0]  links,
    output logic              active,
    output logic              drop
);
    typedef struct packed {
        logic [SLOTS_PER_WINDOW-1:0]             stg_v;
        logic [SLOTS_PER_WINDOW-1:0][WORD_W-1:0] stg_w;
        logic                                    skid_v;
        slot_t                                   skid_slot;
        logic [WORD_W-1:0]                       skid_w;
        logic                                    cur_v;
        logic [WORD_W-1:0]                       cur_w;
    } st_t;

    st_t s_d, s_q;

    always_comb begin
        s_d  = s_q;
        drop = 1'b0;
        // Slot boundary: the staged word of the coming slot becomes current.
        if (slot_end) begin
            s_d.cur_v           = s_q.stg_v[nxt_slot];
            s_d.cur_w           = s_q.stg_w[nxt_slot];
            s_d.stg_v[nxt_slot] = 1'b0;
        end
        // Spare register moves forward once its slot has room.
        if (s_d.skid_v && !s_d.stg_v[s_d.skid_slot]) begin
            s_d.stg_v[s_d.skid_slot] = 1'b1;
            s_d.stg_w[s_d.skid_slot] = s_d.skid_w;
            s_d.skid_v               = 1'b0;
        end
        // New word: own slot first, spare register second.
        if (in_v) begin
            if (!s_d.stg_v[in_slot]) begin
                s_d.stg_v[in_slot] = 1'b1;
                s_d.stg_w[in_slot] = in_word;
            end else if (!s_d.skid_v) begin
                s_d.skid_v    = 1'b1;
                s_d.skid_slot = in_slot;
                s_d.skid_w    = in_word;
            end else begin
                drop = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    for (genvar k = 0; k < LINKS; k++) begin : g_link
        logic [BEATS-1:0] lane;
        assign lane     = s_q.cur_w[k*BEATS +: BEATS];
        assign links[k] = s_q.cur_v & lane[beat_idx];
    end

    assign active = s_q.cur_v;
endmodule

// File: rtl/mtil_interleaver.sv
module mtil_interleaver
    import mtil_pkg::*;
#(
    parameter int unsigned LINKS_PER_HALF = 8,
    parameter int unsigned BEATS = 8,
    parameter int unsigned BANK_W = 4,
    localparam int unsigned WORD_W = LINKS_PER_HALF * BEATS,
    localparam int unsigned BEAT_W = $clog2(BEATS),
    localparam int unsigned PH_W = BEAT_W + 1
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic                             col_valid,
    input  logic [BANK_W-1:0]                col_bank,
    input  logic [WORD_W-1:0]                col_data,
    output logic [NUM_HALVES*LINKS_PER_HALF-1:0] link_o,
    output logic                             beat_a_o,
    output logic                             beat_b_o
);
    logic [PH_W-1:0]       ph;
    logic                  slot_end;
    slot_t                 nxt_slot;
    slot_t                 col_slot;
    logic [NUM_HALVES-1:0] beat;
    logic [NUM_HALVES-1:0] drop;
    logic                  unused_bank;

    assign col_slot    = col_bank[BANK_W-1];
    assign unused_bank = ^col_bank;

    mtil_phase #(.BEATS(BEATS)) u_phase (
        .clk      (clk),
        .rst_n    (rst_n),
        .ph       (ph),
        .slot_end (slot_end),
        .nxt_slot (nxt_slot)
    );

    for (genvar h = 0; h < NUM_HALVES; h++) begin : g_half
        mtil_half #(.LINKS(LINKS_PER_HALF), .BEATS(BEATS)) u_half (
            .clk      (clk),
            .rst_n    (rst_n),
            .beat_idx (ph[BEAT_W-1:0]),
            .slot_end (slot_end),
            .nxt_slot (nxt_slot),
            .in_v     (col_valid && (col_bank[0] == 1'(h))),
            .in_slot  (col_slot),
            .in_word  (col_data),
            .links    (link_o[h*LINKS_PER_HALF +: LINKS_PER_HALF]),
            .active   (beat[h]),
            .drop     (drop[h])
        );
    end

    assign beat_a_o = beat[0];
    assign beat_b_o = beat[1];
endmodule

// File: rtl/mtil_chk.sv
module mtil_chk #(
    parameter int unsigned LINKS = 8,
    parameter int unsigned BEATS = 8,
    localparam int unsigned BEAT_W = $clog2(BEATS),
    localparam int unsigned PH_W = BEAT_W + 1
) (
    input logic             clk,
    input logic             rst_n,
    input logic [PH_W-1:0]  ph,
    input logic [2*LINKS-1:0] link_o,
    input logic             beat_a,
    input logic             beat_b,
    input logic             drop_a,
    input logic             drop_b
);
    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n) !(drop_a || drop_b)); // R9
    AST_PHASE_STEP: assert property (@(posedge clk) disable iff (!rst_n) 1'b1 |=> ph == $past(ph) + PH_W'(1)); // R2
    AST_START_ALIGN_A: assert property (@(posedge clk) disable iff (!rst_n) $rose(beat_a) |-> ph[BEAT_W-1:0] == '0); // R2
    AST_START_ALIGN_B: assert property (@(posedge clk) disable iff (!rst_n) $rose(beat_b) |-> ph[BEAT_W-1:0] == '0); // R2
    AST_HOLD_A: assert property (@(posedge clk) disable iff (!rst_n) (beat_a && ph[BEAT_W-1:0] != '1) |=> beat_a); // R5
    AST_HOLD_B: assert property (@(posedge clk) disable iff (!rst_n) (beat_b && ph[BEAT_W-1:0] != '1) |=> beat_b); // R5
    AST_IDLE_A: assert property (@(posedge clk) disable iff (!rst_n) !beat_a |-> link_o[LINKS-1:0] == '0); // R6
    AST_IDLE_B: assert property (@(posedge clk) disable iff (!rst_n) !beat_b |-> link_o[2*LINKS-1:LINKS] == '0); // R6
endmodule

bind mtil_interleaver mtil_chk #(.LINKS(LINKS_PER_HALF), .BEATS(BEATS)) u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .ph     (ph),
    .link_o (link_o),
    .beat_a (beat_a_o),
    .beat_b (beat_b_o),
    .drop_a (drop[0]),
    .drop_b (drop[1])
);

// File: tb/sim_mtil_interleaver.sv
module sim_mtil_interleaver;
    localparam int L = 8;
    localparam int B = 8;
    localparam int W = L * B;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          col_valid = 1'b0;
    logic [3:0]    col_bank = '0;
    logic [W-1:0]  col_data = '0;
    logic [2*L-1:0] link_o;
    logic          beat_a_o, beat_b_o;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    // Transaction-level model: per half and quadrant a queue of up to two words.
    int           m_ph;
    bit           m_cv [2];
    logic [W-1:0] m_cw [2];
    logic [W-1:0] m_f  [2][2][2];
    int           m_cnt[2][2];

    always #10 clk = ~clk;

    mtil_interleaver u0 (
        .clk(clk), .rst_n(rst_n), .col_valid(col_valid), .col_bank(col_bank),
        .col_data(col_data), .link_o(link_o), .beat_a_o(beat_a_o), .beat_b_o(beat_b_o)
    );

    function automatic logic [L-1:0] exp_links(bit v, logic [W-1:0] w, int beat);
        logic [L-1:0] r;
        for (int k = 0; k < L; k++) r[k] = v ? w[k*B + beat] : 1'b0;
        return r;
    endfunction

    task automatic chk(string tag, string what, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h ph=%0d", tag, what, act, exp, m_ph);
        end
    endtask

    task automatic compare_all();
        for (int h = 0; h < 2; h++) begin
            chk(m_cv[h] ? "R4" : "R6", "links", 64'(link_o[h*L +: L]),
                64'(exp_links(m_cv[h], m_cw[h], m_ph % B)));
            chk("R5", "beat marker", 64'(h == 0 ? beat_a_o : beat_b_o), 64'(m_cv[h]));
        end
    endtask

    function automatic bit can_send(logic [3:0] bank);
        int h = int'(bank[0]);
        int s = int'(bank[3]);
        return (m_cnt[h][s] < 2) && (m_cnt[h][0] + m_cnt[h][1] < 3);
    endfunction

    task automatic step(bit v, logic [3:0] bank, logic [W-1:0] d);
        compare_all();
        col_valid = v;
        col_bank  = bank;
        col_data  = d;
        if ((m_ph % B) == B - 1) begin
            int s = (m_ph < B) ? 1 : 0;
            for (int h = 0; h < 2; h++) begin
                if (m_cnt[h][s] > 0) begin
                    m_cv[h] = 1'b1;
                    m_cw[h] = m_f[h][s][0];
                    m_f[h][s][0] = m_f[h][s][1];
                    m_cnt[h][s]--;
                end else begin
                    m_cv[h] = 1'b0;
                end
            end
        end
        if (v) begin
            int h = int'(bank[0]);
            int s = int'(bank[3]);
            m_f[h][s][m_cnt[h][s]] = d;
            m_cnt[h][s]++;
        end
        m_ph = (m_ph + 1) % (2 * B);
        @(negedge clk);
    endtask

    task automatic wait_ph(int p);
        while (m_ph != p) step(1'b0, 4'd0, '0);
    endtask

    task automatic summary();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
    endtask

    initial begin
        logic [W-1:0] d1, d2, d3, d4, d5, d6, d7;
        d1 = 64'h0123_4567_89ab_cdef;
        d2 = 64'hfedc_ba98_7654_3210;
        d3 = 64'h1111_2222_3333_4444;
        d4 = 64'ha5a5_5a5a_c3c3_3c3c;
        d5 = 64'h8000_0000_0000_0001;
        d6 = 64'h00ff_00ff_f0f0_0f0f;
        d7 = 64'h7e7e_8181_1248_8421;
        void'($urandom(32'd2024));
        m_ph = 0;
        for (int h = 0; h < 2; h++) begin
            m_cv[h] = 1'b0;
            m_cw[h] = '0;
            m_cnt[h][0] = 0;
            m_cnt[h][1] = 0;
        end

        repeat (3) @(negedge clk);
        chk("R1", "links in reset", 64'(link_o), 64'd0);
        chk("R1", "markers in reset", 64'({beat_a_o, beat_b_o}), 64'd0);
        rst_n = 1'b1;

        // R7 on time, R3 routing of an odd upper bank, R2 slot end
        wait_ph(6);
        step(1'b1, 4'd9, d1);
        step(1'b0, 4'd0, '0);
        chk("R7", "B marker at upper slot start", 64'(beat_b_o), 64'd1);
        chk("R3", "A half silent", 64'(link_o[L-1:0]), 64'd0);
        chk("R3", "B half beat 0", 64'(link_o[2*L-1:L]), 64'(exp_links(1'b1, d1, 0)));
        repeat (8) step(1'b0, 4'd0, '0);
        chk("R2", "B marker off after slot", 64'(beat_b_o), 64'd0);

        // R7 late word misses the slot by one cycle
        wait_ph(7);
        step(1'b1, 4'd8, d2);
        chk("R7", "late word not sent yet", 64'(beat_a_o), 64'd0);
        repeat (16) step(1'b0, 4'd0, '0);
        chk("R7", "late word next window", 64'(link_o[L-1:0]), 64'(exp_links(1'b1, d2, 0)));

        // R8 order and R9 three pending words on one half
        repeat (32) step(1'b0, 4'd0, '0);
        wait_ph(1);
        step(1'b1, 4'd0, d3);
        step(1'b1, 4'd2, d4);
        step(1'b1, 4'd8, d5);
        wait_ph(8);
        chk("R9", "upper word bypasses", 64'(link_o[L-1:0]), 64'(exp_links(1'b1, d5, 0)));
        wait_ph(0);
        chk("R8", "first lower word", 64'(link_o[L-1:0]), 64'(exp_links(1'b1, d3, 0)));
        wait_ph(8);
        chk("R9", "upper slot idle", 64'(beat_a_o), 64'd0);
        wait_ph(0);
        chk("R8", "second lower word", 64'(link_o[L-1:0]), 64'(exp_links(1'b1, d4, 0)));

        // R10 both halves in the same slot
        repeat (32) step(1'b0, 4'd0, '0);
        wait_ph(3);
        step(1'b1, 4'd1, d6);
        step(1'b1, 4'd0, d7);
        wait_ph(0);
        chk("R10", "A half shared slot", 64'(link_o[L-1:0]), 64'(exp_links(1'b1, d7, 0)));
        chk("R10", "B half shared slot", 64'(link_o[2*L-1:L]), 64'(exp_links(1'b1, d6, 0)));

        // Constrained random traffic
        repeat (3000) begin
            logic [3:0]   bk;
            logic [W-1:0] dt;
            bk = 4'($urandom % 16);
            dt = {$urandom, $urandom};
            if (($urandom % 2 == 0) && can_send(bk)) step(1'b1, bk, dt);
            else step(1'b0, 4'd0, '0);
        end
        repeat (48) step(1'b0, 4'd0, '0);

        done = 1'b1;
        summary();
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog R1 actual=running expected=finished");
            summary();
            $finish;
        end
    end
endmodule